// File: doc/BRIEF.md
# Multi-Line Configurable Edge Detector

This block watches a wide bank of single-bit signals and flags, line by line, the clock cycles in which a chosen kind of transition occurred. Each line has its own 2-bit edge selector: rising, falling, either direction, or a reserved "off" code. Each line also has its own report-enable bit. Lines whose report bit is clear never produce events. All settings live in 32-bit words that are reached through a simple word-addressed write port. The read port is combinational.

A global enable bit runs a two-state sequencer. In `ST_IDLE` nothing is reported. When enable is seen high, the transition `ST_IDLE -> ST_WATCH` takes one sample of the lines into a previous-value register and reports nothing. In `ST_WATCH` with enable high (`ST_WATCH -> ST_WATCH`), every clock compares the lines with the previous sample. The results go to a registered event vector and a registered any-event flag. When enable is seen low, the transition `ST_WATCH -> ST_IDLE` clears the outputs. Software writes the selectors and report bits first and then sets enable. Changes made while watching take effect at once.

Top module: `edge_watch_bank`

## Requirements
- R1: After reset the event vector and any-event flag are 0, and every register word reads 0 (all selectors code 0, all report bits clear, enable clear).
- R2: A write to a mapped word is returned unchanged by a read of that word. For the control word, only bit 0 (enable) is stored and the other bits read 0.
- R3: Selector code 0 reports a line whose sample went 0 to 1.
- R4: Selector code 1 reports a line whose sample went 1 to 0.
- R5: Selector code 2 reports a line whose sample changed in either direction.
- R6: Selector code 3 is stored and read back, but the line never reports an event.
- R7: A line reports an event only while its report bit is 1.
- R8: With NUM_LINES=256, the address map is as follows. Words 0..15 hold the selectors, with line n at word n/16, bits 2*(n mod 16)+1:2*(n mod 16). Words 16..23 hold the report bits, with line n at word 16+n/32, bit n mod 32. Word 24 bit 0 is the enable.
- R9: The first clock edge that sees enable high only loads the previous-value register. The event vector after it is 0 whatever the lines do.
- R10: A transition sampled at clock edge k, against the sample at edge k-1, appears on the event output after edge k and lasts one cycle.
- R11: Edges sampled at the clock edge that stores enable=0 are still reported. From the next edge on, the outputs are 0 until re-enabled.
- R12: The any-event flag is 1 exactly when at least one bit of the event vector is 1.
- R13: Writes to unmapped word addresses (25..31) change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the register port |
| cfg_addr | input | ADDR_W | Word address for write and read |
| cfg_wdata | input | DATA_W | Write data |
| cfg_rdata | output | DATA_W | Read data of the addressed word (combinational) |
| lines_in | input | NUM_LINES | Monitored signals |
| event_out | output | NUM_LINES | Registered per-line event vector |
| event_any | output | 1 | Registered OR of the event vector |

## Verification
The bench builds the block with its defaults: 256 lines, 32-bit words and a 5-bit address. With these values the top selector word (15), the top report word (23) and line 255 are all reachable. The control word sits at 24, which leaves 25..31 as unmapped addresses to probe. A behavioural model, indexed per line, mirrors every selector code, report bit and enable change. It is compared with the event vector and the flag on every clock, including mid-run reconfiguration, disable with pending edges, and re-enable.

// File: rtl/edge_det_pkg.sv
package edge_det_pkg;

    typedef enum logic [1:0] {
        EC_RISE = 2'd0,
        EC_FALL = 2'd1,
        EC_BOTH = 2'd2,
        EC_NONE = 2'd3
    } edge_code_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WATCH = 1'b1
    } mon_state_e;

endpackage

// File: rtl/edge_cfg_regs.sv
module edge_cfg_regs #(
    parameter int NUM_LINES = 256,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rd_data,
    output logic [2*NUM_LINES-1:0] code_flat,
    output logic [NUM_LINES-1:0]   mask_flat,
    output logic                   enable
);
    localparam int CODES_PER_WORD = DATA_W / 2;
    localparam int CODE_WORDS     = NUM_LINES / CODES_PER_WORD;
    localparam int MASK_WORDS     = NUM_LINES / DATA_W;
    localparam int MASK_BASE      = CODE_WORDS;
    localparam int CTRL_ADDR      = CODE_WORDS + MASK_WORDS;

    logic en_q;

    // selector words
    for (genvar w = 0; w < CODE_WORDS; w++) begin : g_code
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && addr == ADDR_W'(w)) begin
                word_q <= wdata;
            end
        end
        assign code_flat[w*DATA_W +: DATA_W] = word_q;
    end

    // report-enable words
    for (genvar m = 0; m < MASK_WORDS; m++) begin : g_mask
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && addr == ADDR_W'(MASK_BASE + m)) begin
                word_q <= wdata;
            end
        end
        assign mask_flat[m*DATA_W +: DATA_W] = word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (wr_en && addr == ADDR_W'(CTRL_ADDR)) begin
            en_q <= wdata[0];
        end
    end

    assign enable = en_q;

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < CODE_WORDS; w++) begin
            if (addr == ADDR_W'(w)) rd_data = code_flat[w*DATA_W +: DATA_W];
        end
        for (int m = 0; m < MASK_WORDS; m++) begin
            if (addr == ADDR_W'(MASK_BASE + m)) rd_data = mask_flat[m*DATA_W +: DATA_W];
        end
        if (addr == ADDR_W'(CTRL_ADDR)) rd_data = {{(DATA_W-1){1'b0}}, en_q};
    end

endmodule

// File: rtl/edge_seq.sv
module edge_seq
    import edge_det_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    output mon_state_e state,
    output logic       load_prev,
    output logic       report
);
    mon_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (enable)  state_d = ST_WATCH;
            ST_WATCH: if (!enable) state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_prev = 1'b0;
        report    = 1'b0;
        unique case (state_q)
            ST_IDLE:  load_prev = enable;
            ST_WATCH: begin
                load_prev = enable;
                report    = enable;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/edge_lane.sv
module edge_lane
    import edge_det_pkg::*;
(
    input  logic       cur,
    input  logic       prev,
    input  logic [1:0] code,
    input  logic       keep,
    output logic       hit
);
    logic raw;

    always_comb begin
        raw = 1'b0;
        unique case (edge_code_e'(code))
            EC_RISE: raw = cur & ~prev;
            EC_FALL: raw = ~cur & prev;
            EC_BOTH: raw = cur ^ prev;
            EC_NONE: raw = 1'b0;
        endcase
    end

    assign hit = keep & raw;

endmodule

// File: rtl/edge_watch_bank.sv
module edge_watch_bank
    import edge_det_pkg::*;
#(
    parameter int NUM_LINES = 256,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = $clog2(NUM_LINES / (DATA_W / 2) + NUM_LINES / DATA_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic [NUM_LINES-1:0] lines_in,
    output logic [NUM_LINES-1:0] event_out,
    output logic                 event_any
);
    logic [2*NUM_LINES-1:0] code_flat;
    logic [NUM_LINES-1:0]   mask_flat;
    logic                   cfg_en;
    mon_state_e             seq_state;
    logic                   load_prev;
    logic                   report;
    logic                   watching;
    logic [NUM_LINES-1:0]   prev_q;
    logic [NUM_LINES-1:0]   hit;
    logic [NUM_LINES-1:0]   evt_q;
    logic                   any_q;

    edge_cfg_regs #(
        .NUM_LINES (NUM_LINES),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rd_data   (cfg_rdata),
        .code_flat (code_flat),
        .mask_flat (mask_flat),
        .enable    (cfg_en)
    );

    edge_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_en),
        .state     (seq_state),
        .load_prev (load_prev),
        .report    (report)
    );

    assign watching = (seq_state == ST_WATCH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         prev_q <= '0;
        else if (load_prev) prev_q <= lines_in;
    end

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_lane
        edge_lane u_lane (
            .cur  (lines_in[n]),
            .prev (prev_q[n]),
            .code (code_flat[2*n +: 2]),
            .keep (mask_flat[n]),
            .hit  (hit[n])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
            any_q <= 1'b0;
        end else begin
            evt_q <= report ? hit : '0;
            any_q <= report & (|hit);
        end
    end

    assign event_out = evt_q;
    assign event_any = any_q;

endmodule

// File: rtl/edge_watch_bank_chk.sv
module edge_watch_bank_chk #(
    parameter int NUM_LINES = 256
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   enable,
    input logic                   watching,
    input logic [2*NUM_LINES-1:0] code_flat,
    input logic [NUM_LINES-1:0]   mask_flat,
    input logic [NUM_LINES-1:0]   event_out,
    input logic                   event_any
);
    logic [NUM_LINES-1:0] reserved_vec;

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_rsv
        assign reserved_vec[n] = &code_flat[2*n +: 2];
    end

    AST_ANY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        event_any == (|event_out)); // R12

    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (event_out & ~$past(mask_flat)) == '0); // R7

    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (event_out & $past(reserved_vec)) == '0); // R6

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> event_out == '0); // R11

    AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(watching) |-> event_out == '0); // R9

    AST_ARM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!watching && enable) |=> watching); // R9

endmodule

bind edge_watch_bank edge_watch_bank_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (cfg_en),
    .watching  (watching),
    .code_flat (code_flat),
    .mask_flat (mask_flat),
    .event_out (event_out),
    .event_any (event_any)
);

// File: tb/tb_edge_watch_bank.sv
module tb_edge_watch_bank;
    localparam int N  = 256;
    localparam int AW = 5;
    localparam int CW = N / 16;
    localparam int MW = N / 32;
    localparam int CTRL = CW + MW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [N-1:0]  lines_in = '0;
    logic [N-1:0]  event_out;
    logic          event_any;

    int checks = 0;
    int errors = 0;

    // behavioural model
    bit [1:0]  m_code [N];
    bit        m_mask [N];
    bit        m_en = 1'b0;
    bit        m_watch = 1'b0;
    bit [N-1:0] m_prev = '0;
    bit [N-1:0] m_evt = '0;

    edge_watch_bank dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .lines_in  (lines_in),
        .event_out (event_out),
        .event_any (event_any)
    );

    always #5 clk = ~clk;

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic logic [31:0] exp_word(int a);
        logic [31:0] r = '0;
        if (a < CW) begin
            for (int k = 0; k < 16; k++) r[2*k +: 2] = m_code[a*16 + k];
        end else if (a < CW + MW) begin
            for (int k = 0; k < 32; k++) r[k] = m_mask[(a - CW)*32 + k];
        end else if (a == CTRL) begin
            r[0] = m_en;
        end
        return r;
    endfunction

    task automatic model_edge();
        bit [N-1:0] nxt = '0;
        if (m_watch && m_en) begin
            for (int n = 0; n < N; n++) begin
                if (m_mask[n]) begin
                    case (m_code[n])
                        2'd0: nxt[n] = lines_in[n] && !m_prev[n];
                        2'd1: nxt[n] = !lines_in[n] && m_prev[n];
                        2'd2: nxt[n] = lines_in[n] != m_prev[n];
                        default: nxt[n] = 1'b0;
                    endcase
                end
            end
        end
        m_evt = nxt;
        if (!m_watch) begin
            if (m_en) begin
                m_prev  = lines_in;
                m_watch = 1'b1;
            end
        end else if (m_en) begin
            m_prev = lines_in;
        end else begin
            m_watch = 1'b0;
        end
        if (cfg_wr) begin
            int a = int'(cfg_addr);
            if (a < CW) begin
                for (int k = 0; k < 16; k++) m_code[a*16 + k] = cfg_wdata[2*k +: 2];
            end else if (a < CW + MW) begin
                for (int k = 0; k < 32; k++) m_mask[(a - CW)*32 + k] = cfg_wdata[k];
            end else if (a == CTRL) begin
                m_en = cfg_wdata[0];
            end
        end
    endtask

    task automatic compare(string tag);
        checks++;
        if (event_out !== m_evt) begin
            errors++;
            $display("FAIL %s events: got %h expected %h", tag, event_out, m_evt);
        end
        checks++;
        if (event_any !== (|m_evt)) begin
            errors++;
            $display("FAIL R12 any flag (%s): got %b expected %b", tag, event_any, |m_evt);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cfg_wr = 1'b0;
        compare(tag);
    endtask

    task automatic wr(int a, logic [31:0] d, string tag);
        cfg_wr    = 1'b1;
        cfg_addr  = AW'(a);
        cfg_wdata = d;
        step(tag);
    endtask

    task automatic rd_check(int a, string tag);
        cfg_addr = AW'(a);
        #1;
        checks++;
        if (cfg_rdata !== exp_word(a)) begin
            errors++;
            $display("FAIL %s read word %0d: got %h expected %h", tag, a, cfg_rdata, exp_word(a));
        end
    endtask

    initial begin
        for (int n = 0; n < N; n++) begin
            m_code[n] = 2'd0;
            m_mask[n] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        compare("R1");
        for (int a = 0; a < 32; a++) rd_check(a, "R1");

        // R2 / R8: map and readback
        wr(0, 32'h0000_0000, "R2");
        wr(1, 32'h5555_5555, "R2");
        wr(2, 32'hAAAA_AAAA, "R2");
        wr(3, 32'hFFFF_FFFF, "R6");
        wr(15, 32'h1B1B_1B1B, "R8");
        wr(CW + 0, 32'hFFFF_FFFF, "R8");
        wr(CW + 1, 32'hFFFF_FFFF, "R8");
        wr(CW + 3, 32'h0000_0000, "R7");
        wr(CW + 7, 32'hFFFF_FFFF, "R8");
        for (int a = 0; a < CTRL; a++) rd_check(a, "R2");

        // R13: unmapped writes ignored
        wr(25, 32'hFFFF_FFFF, "R13");
        wr(31, 32'hFFFF_FFFF, "R13");
        for (int a = CTRL; a < 32; a++) rd_check(a, "R13");

        // enable (only bit 0 kept)
        wr(CTRL, 32'hFFFF_FFFF, "R2");
        rd_check(CTRL, "R2");

        // R9: first sample after enable quiet
        lines_in = '1;
        step("R9");
        // R4 falling / R5 both / R6 reserved
        lines_in = '0;
        step("R4");
        // R3 rising
        lines_in = '1;
        step("R3");
        lines_in = {8{32'h0F0F_3C3C}};
        step("R5");
        lines_in = {8{32'hF0F0_C3C3}};
        step("R5");
        step("R10");

        // R10: single line, one-cycle latency
        lines_in = '0;
        step("R10");
        wr(CW + 6, 32'h0000_0100, "R10");
        lines_in[200] = 1'b1;
        step("R10");
        checks++;
        if (event_out[200] !== 1'b1) begin
            errors++;
            $display("FAIL R10 line 200: got %b expected 1", event_out[200]);
        end
        step("R10");
        checks++;
        if (event_out[200] !== 1'b0) begin
            errors++;
            $display("FAIL R10 line 200 hold: got %b expected 0", event_out[200]);
        end

        // R6: live change to reserved code on word 0
        wr(0, 32'hFFFF_FFFF, "R6");
        rd_check(0, "R6");
        lines_in = '1;
        step("R6");
        // R7: clear report bits of word 16
        wr(CW + 0, 32'h0000_0000, "R7");
        wr(0, 32'h0000_0000, "R7");
        lines_in = '0;
        step("R7");
        lines_in = '1;
        step("R7");

        // R11: disable with edges pending
        lines_in = '0;
        cfg_wr = 1'b1; cfg_addr = AW'(CTRL); cfg_wdata = 32'h0;
        step("R11");
        lines_in = '1;
        step("R11");
        lines_in = '0;
        step("R11");
        checks++;
        if (event_out !== '0) begin
            errors++;
            $display("FAIL R11 disabled: got %h expected 0", event_out);
        end

        // re-enable: first sample quiet again
        wr(CTRL, 32'h1, "R9");
        lines_in = '1;
        step("R9");
        checks++;
        if (event_out !== '0) begin
            errors++;
            $display("FAIL R9 re-enable: got %h expected 0", event_out);
        end

        // random traffic with all masks open and mixed codes
        for (int m = 0; m < MW; m++) wr(CW + m, 32'hFFFF_FFFF, "R7");
        for (int w = 0; w < CW; w++) wr(w, $urandom(), "R5");
        for (int i = 0; i < 300; i++) begin
            lines_in = {8{$urandom()}};
            if (i % 50 == 7) begin
                cfg_wr = 1'b1;
                cfg_addr = AW'(i % CW);
                cfg_wdata = $urandom();
            end
            step("R12");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule